// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 36-bit physical address by fetching descriptors from memory, one word at a time. A walk begins at a context table, which is located by a table pointer and indexed by a context number. It then passes through a region table, a segment table and a page table. At the first three levels the fetched word must be a pointer to the next table. At the last level it must be a final page entry. That entry supplies the physical page number, a cacheable flag and a three-bit protection code. The code is checked against the access's write flag and user flag.

When the walk succeeds, the block sets the referenced bit of the final entry, and also the modified bit if the access is a write. It writes the entry back only when one of these bits actually changes. The result is a single-cycle response. That response carries either the physical address with its cacheable flag, or a fault together with the level where the walk stopped. The memory port allows one request in flight at a time and is shared by the reads and the writeback.

Top module: `ptw_top`

## Requirements
- R1: The low two bits of a fetched word give its kind: 0 invalid, 1 pointer to the next table, 2 final page entry, 3 reserved. At the context, region and segment levels, any kind other than 1 ends the walk with a fault at level code 0, 1 or 2 respectively.
- R2: At the page level, any kind other than 2 ends the walk with a fault at level code 3.
- R3: The context entry is read at byte address ((tbl_ptr >> 2) << 6) | (ctx_id << 2), taken to 32 bits and zero-extended.
- R4: Each later read uses the byte address ((pointer >> 2) << 6) | (index << 2), where pointer is the previous word. The index is va[31:24] for the region table (256 entries), va[23:18] for the segment table (64) and va[17:12] for the page table (64).
- R5: A successful walk returns rsp_pa = {entry[31:8], va[11:0]} and rsp_cacheable = entry[7].
- R6: With the protection code in entry[4:2], a user access whose code is above 5 faults at level 3.
- R7: A write faults at level 3 unless the code allows writing in the current mode: codes 1 and 3 for user, and codes 1, 3, 5 and 7 for supervisor.
- R8: A successful walk writes the entry back to its own address with bit 5 (referenced) set, and with bit 6 (modified) also set for a write.
- R9: The writeback is left out when those bits already hold their target values. The walk then uses exactly four memory accesses.
- R10: A faulting walk issues no memory write.
- R11: mem_req stays high, with mem_addr and mem_we unchanged, until mem_ack. No request is made while busy is low.
- R12: After reset, busy, mem_req and rsp_valid are low. req_valid is ignored while busy is high, and rsp_valid lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_ptr | input | 32 | Context table pointer |
| ctx_id | input | CTX_W | Context number, sampled at start |
| req_valid | input | 1 | Start a walk (taken when busy is low) |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is in user mode |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 36 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the current request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk faulted |
| rsp_level | output | 2 | Fault level: 0 context, 1 region, 2 segment, 3 page |
| rsp_pa | output | 36 | Physical address |
| rsp_cacheable | output | 1 | Cacheable flag from the entry |

## Verification
A complete four-level table set is reached through context 3 and exercised with every protection code under each combination of the user and write flags. This separates user limits from supervisor limits and shows which access fails only on a write. Repeated walks on the same entry tell the writeback that changes bits apart from the case where the writeback is left out. A separate set of broken chains places invalid, reserved and wrong-kind words at each level, so that each fault level code is produced. A walk through context 15 with all-ones indices shows that index bits do not spill into the table base.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 36;
  localparam int OFF_W   = 12;
  localparam int REG_IW  = 8;
  localparam int SEG_IW  = 6;
  localparam int PG_IW   = 6;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int BIT_C   = 7;
  localparam int BIT_M   = 6;
  localparam int BIT_R   = 5;
  localparam int PROT_LO = 2;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0, ET_PTD = 2'd1, ET_PTE = 2'd2, ET_RSVD = 2'd3
  } ent_kind_t;

  typedef enum logic [1:0] {
    LV_CTX = 2'd0, LV_REG = 2'd1, LV_SEG = 2'd2, LV_PAGE = 2'd3
  } walk_lvl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CTX, S_REG, S_SEG, S_PAGE, S_WB, S_DONE
  } walk_st_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int CTX_W = 4
) (
  input  walk_lvl_t              lvl,
  input  logic [31:0]            tbl_ptr,
  input  logic [CTX_W-1:0]       ctx,
  input  logic [31:0]            ptd,
  input  logic [VPN_W-1:0]       vpn,
  output logic [PA_W-1:0]        addr
);
  localparam int PG_LO  = 0;
  localparam int SEG_LO = PG_IW;
  localparam int REG_LO = PG_IW + SEG_IW;

  logic [31:0]     ctx_addr;
  logic [PA_W-1:0] base;
  logic [7:0]      idx;

  always_comb begin
    ctx_addr = ((tbl_ptr >> 2) << 6) | (32'(ctx) << 2);
    base     = ((PA_W'(ptd)) >> 2) << 6;
    unique case (lvl)
      LV_REG:  idx = 8'(vpn[REG_LO +: REG_IW]);
      LV_SEG:  idx = 8'(vpn[SEG_LO +: SEG_IW]);
      default: idx = 8'(vpn[PG_LO  +: PG_IW]);
    endcase
    if (lvl == LV_CTX) addr = PA_W'(ctx_addr);
    else               addr = base | (PA_W'(idx) << 2);
  end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm (
  input  logic [2:0] prot,
  input  logic       user,
  input  logic       write,
  output logic       deny
);
  logic may_write;
  always_comb begin
    may_write = prot[0] && !(user && prot[2]);
    deny      = (user && (prot > 3'd5)) || (write && !may_write);
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int CTX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      tbl_ptr,
  input  logic [CTX_W-1:0] ctx_id,
  input  logic             req_valid,
  input  logic [31:0]      req_va,
  input  logic             req_write,
  input  logic             req_user,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_level,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_cacheable
);
  walk_st_t        st;
  logic [31:0]     va_q;
  logic            wr_q, usr_q;
  walk_lvl_t       nxt_lvl, cur_lvl;
  logic [PA_W-1:0] gen_addr;
  logic            deny;
  logic [31:0]     upd;
  ent_kind_t       kind;

  always_comb begin
    unique case (st)
      S_CTX:   begin nxt_lvl = LV_REG;  cur_lvl = LV_CTX; end
      S_REG:   begin nxt_lvl = LV_SEG;  cur_lvl = LV_REG; end
      S_SEG:   begin nxt_lvl = LV_PAGE; cur_lvl = LV_SEG; end
      default: begin nxt_lvl = LV_CTX;  cur_lvl = LV_PAGE; end
    endcase
    kind = ent_kind_t'(mem_rdata[1:0]);
    upd  = mem_rdata | (32'd1 << BIT_R) | (wr_q ? (32'd1 << BIT_M) : 32'd0);
  end

  ptw_addr_gen #(.CTX_W(CTX_W)) u_addr (
    .lvl     (nxt_lvl),
    .tbl_ptr (tbl_ptr),
    .ctx     (ctx_id),
    .ptd     (mem_rdata),
    .vpn     (st == S_IDLE ? req_va[VA_W-1:OFF_W] : va_q[VA_W-1:OFF_W]),
    .addr    (gen_addr)
  );

  ptw_perm u_perm (
    .prot  (mem_rdata[PROT_LO +: 3]),
    .user  (usr_q),
    .write (wr_q),
    .deny  (deny)
  );

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      va_q          <= '0;
      wr_q          <= 1'b0;
      usr_q         <= 1'b0;
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_level     <= '0;
      rsp_pa        <= '0;
      rsp_cacheable <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          rsp_valid <= 1'b0;
          if (req_valid) begin
            va_q     <= req_va;
            wr_q     <= req_write;
            usr_q    <= req_user;
            mem_addr <= gen_addr;
            mem_we   <= 1'b0;
            mem_req  <= 1'b1;
            st       <= S_CTX;
          end
        end
        S_CTX, S_REG, S_SEG: begin
          if (mem_ack) begin
            if (kind == ET_PTD) begin
              mem_addr <= gen_addr;
              st       <= (st == S_CTX) ? S_REG : (st == S_REG) ? S_SEG : S_PAGE;
            end else begin
              mem_req       <= 1'b0;
              rsp_valid     <= 1'b1;
              rsp_fault     <= 1'b1;
              rsp_level     <= cur_lvl;
              rsp_pa        <= '0;
              rsp_cacheable <= 1'b0;
              st            <= S_DONE;
            end
          end
        end
        S_PAGE: begin
          if (mem_ack) begin
            if (kind != ET_PTE || deny) begin
              mem_req       <= 1'b0;
              rsp_valid     <= 1'b1;
              rsp_fault     <= 1'b1;
              rsp_level     <= LV_PAGE;
              rsp_pa        <= '0;
              rsp_cacheable <= 1'b0;
              st            <= S_DONE;
            end else begin
              rsp_fault     <= 1'b0;
              rsp_level     <= LV_PAGE;
              rsp_pa        <= {mem_rdata[31:8], va_q[OFF_W-1:0]};
              rsp_cacheable <= mem_rdata[BIT_C];
              if (upd != mem_rdata) begin
                mem_we    <= 1'b1;
                mem_wdata <= upd;
                st        <= S_WB;
              end else begin
                mem_req   <= 1'b0;
                rsp_valid <= 1'b1;
                st        <= S_DONE;
              end
            end
          end
        end
        S_WB: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            rsp_valid <= 1'b1;
            st        <= S_DONE;
          end
        end
        default: begin
          rsp_valid <= 1'b0;
          st        <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int AW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          rsp_valid
);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  p_wb_bits_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[1:0] == 2'b10));

  p_wb_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_ack));

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind ptw_top ptw_chk #(.AW(36)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .rsp_valid (rsp_valid)
);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tbl_ptr = 32'h0000_0400;
  logic [3:0]  ctx_id = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0, req_user = 1'b0;
  logic        busy, mem_req, mem_we, mem_ack = 1'b0;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic        rsp_valid, rsp_fault, rsp_cacheable;
  logic [1:0]  rsp_level;
  logic [35:0] rsp_pa;

  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  ptw_top #(.CTX_W(4)) dut (
    .clk(clk), .rst(rst), .tbl_ptr(tbl_ptr), .ctx_id(ctx_id),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_user(req_user),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_pa(rsp_pa), .rsp_cacheable(rsp_cacheable)
  );

  // behavioural memory: word store, one access per request, ack one cycle later
  logic [31:0] mem [logic [33:0]];
  logic [35:0] act_addr[$];
  bit          act_we[$];

  function automatic logic [31:0] rd(input logic [35:0] a);
    return mem.exists(a[35:2]) ? mem[a[35:2]] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      act_addr.push_back(mem_addr);
      act_we.push_back(mem_we);
      if (mem_we) mem[mem_addr[35:2]] = mem_wdata;
      else        mem_rdata <= rd(mem_addr);
      mem_ack <= 1'b1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison: an idle walker never requests memory
  always @(negedge clk) begin
    if (!rst && !busy) chk(!mem_req, "R11 idle request", 64'(mem_req), 0);
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  function automatic logic [31:0] ptd(input logic [35:0] base);
    return {base[35:6], 2'b01};
  endfunction

  function automatic logic [31:0] pte(input logic [23:0] ppn, input bit c, m, r, input logic [2:0] p);
    return {ppn, c, m, r, p, 2'b10};
  endfunction

  task automatic wr(input logic [35:0] a, input logic [31:0] v);
    mem[a[35:2]] = v;
  endtask

  // reference model of one walk, from the requirements
  task automatic run_walk(input logic [3:0] ctx, input logic [31:0] va, input bit w, input bit u,
                          input bit poke, input string tag);
    logic [35:0] ea[$];
    bit          ewe[$];
    logic [35:0] a, pg_a;
    logic [31:0] e, ewb;
    bit          ef = 0, ec = 0, do_wb = 0;
    logic [1:0]  el = 0;
    logic [35:0] epa = 0;
    int          waitc = 0;
    logic [7:0]  idx [3];
    idx[0] = va[31:24]; idx[1] = 8'(va[23:18]); idx[2] = 8'(va[17:12]);
    a = 36'(32'((36'(tbl_ptr) >> 2) * 64 + 36'(ctx) * 4));
    for (int l = 0; l < 4 && !ef; l++) begin
      e = rd(a);
      ea.push_back(a); ewe.push_back(0);
      if (l < 3) begin
        if (e[1:0] != 2'd1) begin ef = 1; el = 2'(l); end
        else a = (36'(e) >> 2) * 64 + 36'(idx[l]) * 4;
      end else begin
        pg_a = a;
        if (e[1:0] != 2'd2) begin ef = 1; el = 3; end
        else if (u && e[4:2] > 5) begin ef = 1; el = 3; end
        else if (w && !(u ? (e[4:2] == 1 || e[4:2] == 3) : e[2])) begin ef = 1; el = 3; end
        else begin
          epa = {e[31:8], va[11:0]};
          ec  = e[7];
          ewb = e | 32'h20 | (w ? 32'h40 : 32'h0);
          do_wb = (ewb != e);
          if (do_wb) begin ea.push_back(a); ewe.push_back(1); end
        end
      end
    end
    act_addr.delete(); act_we.delete();
    @(negedge clk);
    ctx_id = ctx; req_va = va; req_write = w; req_user = u; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    if (poke) begin
      req_valid = 1; req_va = ~va; req_write = ~w;
      @(negedge clk);
      req_valid = 0;
    end
    while (!rsp_valid && waitc < 200) begin @(negedge clk); waitc++; end
    chk(rsp_valid, {tag, " R12 response"}, 64'(rsp_valid), 1);
    chk(rsp_fault == ef, {tag, " R1 R2 R6 R7 fault"}, 64'(rsp_fault), 64'(ef));
    if (ef) chk(rsp_level == el, {tag, " R1 R2 level"}, 64'(rsp_level), 64'(el));
    else begin
      chk(rsp_pa == epa, {tag, " R5 pa"}, 64'(rsp_pa), 64'(epa));
      chk(rsp_cacheable == ec, {tag, " R5 cacheable"}, 64'(rsp_cacheable), 64'(ec));
      if (do_wb) chk(rd(pg_a) == ewb, {tag, " R8 entry"}, 64'(rd(pg_a)), 64'(ewb));
    end
    chk(act_addr.size() == ea.size(), {tag, " R3 R4 R9 R10 access count"},
        64'(act_addr.size()), 64'(ea.size()));
    for (int i = 0; i < ea.size() && i < act_addr.size(); i++) begin
      chk(act_addr[i] == ea[i], {tag, " R3 R4 address"}, 64'(act_addr[i]), 64'(ea[i]));
      chk(act_we[i] == ewe[i], {tag, " R8 R10 write flag"}, 64'(act_we[i]), 64'(ewe[i]));
    end
    @(negedge clk);
    chk(!rsp_valid, {tag, " R12 one-cycle strobe"}, 64'(rsp_valid), 0);
    @(negedge clk);
    chk(!busy, {tag, " R12 no restart"}, 64'(busy), 0);
  endtask

  localparam logic [31:0] VA0 = 32'h1214_7ABC;

  initial begin
    // tables for context 3 (context table at 0x4000)
    wr(36'h400C, ptd(36'h10000));
    wr(36'h10048, ptd(36'h20000));
    wr(36'h20014, ptd(36'h30000));
    // broken chains
    wr(36'h1004C, 32'h3);
    wr(36'h10050, ptd(36'h21000));
    wr(36'h21014, pte(24'h1, 0, 0, 0, 0));
    wr(36'h30020, 32'h1);
    // context 15 with all-ones indices
    wr(36'h403C, ptd(36'h50000));
    wr(36'h503FC, ptd(36'h60000));
    wr(36'h600FC, ptd(36'h70000));
    wr(36'h700FC, pte(24'h876543, 1, 0, 0, 3'd3));

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !mem_req && !rsp_valid, "R12 reset state",
        {61'b0, busy, mem_req, rsp_valid}, 0);

    // R8 R9: first read sets referenced, second read skips writeback
    wr(36'h3001C, pte(24'hABCDE, 1, 0, 0, 3'd0));
    run_walk(4'd3, VA0, 0, 0, 0, "read-first");
    run_walk(4'd3, VA0, 0, 0, 0, "read-again");
    run_walk(4'd3, VA0, 1, 0, 0, "sup-write-code0");
    wr(36'h3001C, pte(24'hABCDE, 0, 0, 1, 3'd1));
    run_walk(4'd3, VA0, 1, 1, 0, "user-write-code1");
    run_walk(4'd3, VA0, 1, 1, 1, "write-again-poked");

    // R6 R7: every protection code, mode and direction
    for (int p = 0; p < 8; p++)
      for (int m = 0; m < 4; m++) begin
        wr(36'h3001C, pte(24'h13579 + 24'(p), p[0], 0, 0, 3'(p)));
        run_walk(4'd3, VA0, m[0], m[1], 0, $sformatf("sweep p%0d m%0d", p, m));
      end

    // R1 R2: fault levels
    run_walk(4'd7, VA0, 0, 0, 0, "ctx-invalid");
    run_walk(4'd3, 32'h1314_7000, 0, 0, 0, "region-reserved");
    run_walk(4'd3, 32'h1414_7000, 0, 0, 0, "segment-final");
    run_walk(4'd3, 32'h1214_8000, 0, 0, 0, "page-pointer");
    run_walk(4'd3, 32'h1214_9000, 0, 0, 0, "page-invalid");

    // R3 R4: highest context and indices
    run_walk(4'd15, 32'hFFFF_FFFF, 1, 1, 0, "all-ones");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule